// File: doc/BRIEF.md
# Single-Bus Byte Datapath with Latched Memory Address

This block is the data path of a small teaching computer. One 8-bit bus connects a 4-bit address register, a 16-byte RAM, two operand registers (A and B) and an adder/subtractor. In every clock cycle an outside controller presents a control word. The word selects the one source that drives the bus and the destinations that capture the bus value at the next rising edge. An external byte source is one of the bus drivers. Through it, stimulus can place addresses and data on the bus. There is no fetch, decode or sequencing logic inside.

Addresses and data share the same wires. The RAM is therefore never indexed by the bus itself. A value is first captured into the address register, which takes only the low nibble of the bus. The RAM then uses that stored address until the next address load. Debug outputs show the address register, both operands, the ALU result and the whole RAM contents. A bench can compare a complete memory image after a program that it sequences by hand.

Top module: `byte_bus_datapath`

## Requirements
- R1: A synchronous active-high reset sets the address register, A and B to zero at the next rising edge. The RAM contents are left unchanged by reset.
- R2: When the address-load control is high, the address register takes bits [3:0] of the bus at the rising edge, and bits [7:4] are ignored. When the control is low, the address register holds its value.
- R3: When the memory-write control is high, the RAM location selected by the address register takes the bus value at the rising edge. No other location changes.
- R4: When the memory-drive control is high, the bus carries the byte at the location selected by the address register, with no clock delay.
- R5: A and B each load the bus value at the rising edge when their own load control is high. Each drives the bus when its own drive control is high.
- R6: The ALU result is A+B modulo 256 when the subtract control is low. It is A-B modulo 256 (A plus inverted B plus a carry-in of 1) when the subtract control is high. The result reaches the bus only when the ALU-drive control is high.
- R7: The bus is all zeros when no drive control is high. At most one drive control may be high in any cycle.
- R8: Start with 15, 4 and 7 stored at addresses 0, 1 and 2. Then compute 15+4, store the sum at address 3, compute 19-7, and store that result at address 4. After this sequence, address 3 holds 19, address 4 holds 12, and every other location keeps its previous value.
- R9: If an address load and a memory write happen in the same cycle, the write goes to the address held before that edge, and the new address applies from the next cycle on. If the ALU drives the bus while A loads, A receives the result computed from the pre-edge operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of address, A and B |
| ext_oe | input | 1 | External byte drives the bus |
| ext_data | input | 8 | External byte value |
| mem_oe | input | 1 | RAM byte at the current address drives the bus |
| a_oe | input | 1 | Register A drives the bus |
| b_oe | input | 1 | Register B drives the bus |
| alu_oe | input | 1 | ALU result drives the bus |
| addr_ld | input | 1 | Address register loads bus bits [3:0] |
| mem_we | input | 1 | RAM location at the current address loads the bus |
| a_ld | input | 1 | Register A loads the bus |
| b_ld | input | 1 | Register B loads the bus |
| alu_sub | input | 1 | ALU subtracts B from A instead of adding |
| bus_o | output | 8 | Current bus value |
| addr_o | output | 4 | Address register contents |
| a_o | output | 8 | Register A contents |
| b_o | output | 8 | Register B contents |
| alu_o | output | 8 | Current ALU result |
| mem_image_o | output | 128 | All RAM bytes; location i at bits [8i+7:8i] |

## Verification
Two functions can fall in the same cycle. One pair is an address load and a memory write. The other is the ALU driving the bus while A loads from it. The bench provokes the first by placing a new address byte on the bus and asserting both address-load and memory-write in a single cycle. The byte must then appear at the old address, the new address location must be untouched, and the address register must show the new nibble. The bench provokes the second by asserting ALU-drive and A-load together twice in a row. A is judged against the sums computed in the bench from the operands held before each edge.

// File: rtl/bbd_pkg.sv
package bbd_pkg;

    // Default geometry of the datapath
    localparam int unsigned BBD_DATA_W = 8;
    localparam int unsigned BBD_ADDR_W = 4;

    // Bus source slots; each slot has one drive enable
    localparam int unsigned SRC_EXT   = 0;
    localparam int unsigned SRC_MEM   = 1;
    localparam int unsigned SRC_A     = 2;
    localparam int unsigned SRC_B     = 3;
    localparam int unsigned SRC_ALU   = 4;
    localparam int unsigned SRC_COUNT = 5;

endpackage

// File: rtl/bbd_bus_mux.sv
module bbd_bus_mux #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SRC_N  = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SRC_N-1:0]          drive_en,
    input  logic [SRC_N*DATA_W-1:0]   src_flat,
    output logic [DATA_W-1:0]         bus
);

    logic [DATA_W-1:0] gated [SRC_N];

    // Each source is masked by its own enable
    for (genvar g = 0; g < SRC_N; g++) begin : g_gate
        assign gated[g] = drive_en[g] ? src_flat[g*DATA_W +: DATA_W] : '0;
    end

    // Combine all masked sources; with no enable the bus reads zero
    always_comb begin
        bus = '0;
        for (int i = 0; i < SRC_N; i++) begin
            bus = bus | gated[i];
        end
    end

    // R7: no two drivers on the shared bus
    assert_one_driver_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive_en))
        else $error("bus driven by more than one source");

endmodule

// File: rtl/bbd_alu.sv
module bbd_alu #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              sub,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] opb_eff;

    // Two's complement subtract: invert B and add a carry-in of one
    always_comb begin
        opb_eff = sub ? ~opb : opb;
        result  = opa + opb_eff + DATA_W'(sub);
    end

endmodule

// File: rtl/bbd_regs.sv
module bbd_regs #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus,
    input  logic              addr_ld,
    input  logic              a_ld,
    input  logic              b_ld,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (addr_ld) st_d.addr = bus[ADDR_W-1:0];
        if (a_ld)    st_d.a    = bus;
        if (b_ld)    st_d.b    = bus;
        if (rst)     st_d      = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr_q = st_q.addr;
    assign a_q    = st_q.a;
    assign b_q    = st_q.b;

    // R1: the cycle after reset all three registers read zero
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q.addr == '0 && st_q.a == '0 && st_q.b == '0))
        else $error("registers not cleared by reset");

    // R2: address takes only the low nibble of the bus
    assert_addr_nibble_R2: assert property (@(posedge clk) disable iff (rst)
        addr_ld |=> st_q.addr == $past(bus[ADDR_W-1:0]))
        else $error("address register load mismatch");

    // R2: address holds without a load
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !addr_ld |=> $stable(st_q.addr))
        else $error("address register changed without load");

endmodule

// File: rtl/bbd_ram.sv
module bbd_ram #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           we,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [(1<<ADDR_W)*DATA_W-1:0]  image
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    // One storage cell per location; no reset on purpose
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we && addr == ADDR_W'(g)) mem_d[g] = wdata;
        end

        always_ff @(posedge clk) begin
            mem_q[g] <= mem_d[g];
        end

        assign image[g*DATA_W +: DATA_W] = mem_q[g];
    end

    // Asynchronous read from the latched address
    assign rdata = mem_q[addr];

    // Checker state: remember the last write to compare after the edge
    logic              chk_vld_q;
    logic [ADDR_W-1:0] chk_addr_q;
    logic [DATA_W-1:0] chk_data_q;

    always_ff @(posedge clk) begin
        chk_vld_q  <= we;
        chk_addr_q <= addr;
        chk_data_q <= wdata;
    end

    // R3: a written byte lands at the address held before the edge
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        chk_vld_q |-> image[chk_addr_q*DATA_W +: DATA_W] == chk_data_q)
        else $error("memory write not stored");

endmodule

// File: rtl/byte_bus_datapath.sv
module byte_bus_datapath
    import bbd_pkg::*;
#(
    parameter int unsigned DATA_W = BBD_DATA_W,
    parameter int unsigned ADDR_W = BBD_ADDR_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ext_oe,
    input  logic [DATA_W-1:0]              ext_data,
    input  logic                           mem_oe,
    input  logic                           a_oe,
    input  logic                           b_oe,
    input  logic                           alu_oe,
    input  logic                           addr_ld,
    input  logic                           mem_we,
    input  logic                           a_ld,
    input  logic                           b_ld,
    input  logic                           alu_sub,
    output logic [DATA_W-1:0]              bus_o,
    output logic [ADDR_W-1:0]              addr_o,
    output logic [DATA_W-1:0]              a_o,
    output logic [DATA_W-1:0]              b_o,
    output logic [DATA_W-1:0]              alu_o,
    output logic [(1<<ADDR_W)*DATA_W-1:0]  mem_image_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0]           bus;
    logic [ADDR_W-1:0]           addr_q;
    logic [DATA_W-1:0]           a_q;
    logic [DATA_W-1:0]           b_q;
    logic [DATA_W-1:0]           alu_res;
    logic [DATA_W-1:0]           mem_rd;
    logic [DEPTH*DATA_W-1:0]     image;
    logic [SRC_COUNT-1:0]        drive_en;
    logic [SRC_COUNT*DATA_W-1:0] src_flat;

    // Pack drive enables and sources into their slots
    always_comb begin
        drive_en          = '0;
        drive_en[SRC_EXT] = ext_oe;
        drive_en[SRC_MEM] = mem_oe;
        drive_en[SRC_A]   = a_oe;
        drive_en[SRC_B]   = b_oe;
        drive_en[SRC_ALU] = alu_oe;

        src_flat = '0;
        src_flat[SRC_EXT*DATA_W +: DATA_W] = ext_data;
        src_flat[SRC_MEM*DATA_W +: DATA_W] = mem_rd;
        src_flat[SRC_A*DATA_W   +: DATA_W] = a_q;
        src_flat[SRC_B*DATA_W   +: DATA_W] = b_q;
        src_flat[SRC_ALU*DATA_W +: DATA_W] = alu_res;
    end

    bbd_bus_mux #(.DATA_W(DATA_W), .SRC_N(SRC_COUNT)) u_mux (
        .clk      (clk),
        .rst      (rst),
        .drive_en (drive_en),
        .src_flat (src_flat),
        .bus      (bus)
    );

    bbd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .addr_ld (addr_ld),
        .a_ld    (a_ld),
        .b_ld    (b_ld),
        .addr_q  (addr_q),
        .a_q     (a_q),
        .b_q     (b_q)
    );

    bbd_alu #(.DATA_W(DATA_W)) u_alu (
        .opa    (a_q),
        .opb    (b_q),
        .sub    (alu_sub),
        .result (alu_res)
    );

    bbd_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr_q),
        .we    (mem_we),
        .wdata (bus),
        .rdata (mem_rd),
        .image (image)
    );

    assign bus_o       = bus;
    assign addr_o      = addr_q;
    assign a_o         = a_q;
    assign b_o         = b_q;
    assign alu_o       = alu_res;
    assign mem_image_o = image;

    // R9: ALU feeding A in the same cycle uses the pre-edge operands
    assert_alu_into_a_R9: assert property (@(posedge clk) disable iff (rst)
        (alu_oe && a_ld) |=> a_q == ($past(alu_sub) ? DATA_W'($past(a_q) - $past(b_q))
                                                    : DATA_W'($past(a_q) + $past(b_q))))
        else $error("A did not receive the pre-edge ALU result");

    // R4: memory drive puts the addressed byte on the bus
    assert_mem_read_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_oe && $onehot(drive_en)) |-> bus_o == mem_image_o[addr_o*DATA_W +: DATA_W])
        else $error("memory read byte not on bus");

endmodule

// File: tb/byte_bus_datapath_tb.sv
module byte_bus_datapath_tb;

    localparam logic [9:0] C_EXT = 10'd1;
    localparam logic [9:0] C_MEM = 10'd2;
    localparam logic [9:0] C_AOE = 10'd4;
    localparam logic [9:0] C_BOE = 10'd8;
    localparam logic [9:0] C_ALU = 10'd16;
    localparam logic [9:0] C_LAD = 10'd32;
    localparam logic [9:0] C_WE  = 10'd64;
    localparam logic [9:0] C_LA  = 10'd128;
    localparam logic [9:0] C_LB  = 10'd256;
    localparam logic [9:0] C_SUB = 10'd512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [9:0] ctl = '0;
    logic [7:0] ext = '0;
    logic [7:0] bus_o, a_o, b_o, alu_o;
    logic [3:0] addr_o;
    logic [127:0] mem_image_o;
    logic [7:0] bus_seen;
    logic [7:0] exp_mem [16];
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    byte_bus_datapath u_dut (
        .clk         (clk),
        .rst         (rst),
        .ext_oe      (ctl[0]),
        .ext_data    (ext),
        .mem_oe      (ctl[1]),
        .a_oe        (ctl[2]),
        .b_oe        (ctl[3]),
        .alu_oe      (ctl[4]),
        .addr_ld     (ctl[5]),
        .mem_we      (ctl[6]),
        .a_ld        (ctl[7]),
        .b_ld        (ctl[8]),
        .alu_sub     (ctl[9]),
        .bus_o       (bus_o),
        .addr_o      (addr_o),
        .a_o         (a_o),
        .b_o         (b_o),
        .alu_o       (alu_o),
        .mem_image_o (mem_image_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, record the pre-edge bus, settle after the rise
    task automatic cyc(input logic [9:0] c, input logic [7:0] v);
        @(negedge clk);
        ctl = c;
        ext = v;
        #1;
        bus_seen = bus_o;
        @(posedge clk);
        #1;
        ctl = '0;
    endtask

    task automatic chk_image(input string tag);
        for (int i = 0; i < 16; i++) begin
            chk(tag, {24'd0, mem_image_o[i*8 +: 8]}, {24'd0, exp_mem[i]});
        end
    endtask

    task automatic mem_write(input logic [3:0] a, input logic [7:0] v);
        cyc(C_EXT | C_LAD, {4'hA, a});
        cyc(C_EXT | C_WE, v);
        exp_mem[a] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state of registers
        rst = 1'b1;
        cyc('0, 8'h00);
        cyc('0, 8'h00);
        chk("R1 addr after reset", {28'd0, addr_o}, 32'd0);
        chk("R1 A after reset", {24'd0, a_o}, 32'd0);
        chk("R1 B after reset", {24'd0, b_o}, 32'd0);
        rst = 1'b0;

        // R2 R3: fill every location, junk in the upper nibble of the address byte
        for (int i = 0; i < 16; i++) begin
            cyc(C_EXT | C_LAD, 8'((i << 4) | 8'h80 | i));
            chk("R2 address low nibble", {28'd0, addr_o}, 32'(i));
            cyc(C_EXT | C_WE, 8'(i * 17 + 3));
            exp_mem[i] = 8'(i * 17 + 3);
            chk_image("R3 fill write");
        end

        // R2: no load keeps the address
        cyc(C_EXT, 8'h07);
        chk("R2 address hold", {28'd0, addr_o}, 32'd15);

        // R4: read every location onto the bus
        for (int i = 0; i < 16; i++) begin
            cyc(C_EXT | C_LAD, 8'(i));
            cyc(C_MEM, 8'h00);
            chk("R4 memory read", {24'd0, bus_seen}, {24'd0, exp_mem[i]});
        end

        // R7: idle bus reads zero
        cyc('0, 8'hFF);
        chk("R7 idle bus", {24'd0, bus_seen}, 32'd0);

        // R5 R6: operand sweep
        for (int x = 0; x < 256; x += 17) begin
            for (int y = 0; y < 256; y += 23) begin
                cyc(C_EXT | C_LA, 8'(x));
                cyc(C_EXT | C_LB, 8'(y));
                chk("R5 A load", {24'd0, a_o}, 32'(x));
                chk("R5 B load", {24'd0, b_o}, 32'(y));
                cyc(C_ALU, 8'h00);
                chk("R6 add", {24'd0, bus_seen}, 32'((x + y) % 256));
                cyc(C_ALU | C_SUB, 8'h00);
                chk("R6 subtract", {24'd0, bus_seen}, 32'((x - y + 256) % 256));
                cyc(C_SUB, 8'h00);
                chk("R6 result gated", {24'd0, bus_seen}, 32'd0);
                chk("R6 result port", {24'd0, alu_o}, 32'((x - y + 256) % 256));
            end
        end

        // R5: A and B drive the bus
        cyc(C_EXT | C_LA, 8'h5C);
        cyc(C_EXT | C_LB, 8'hC3);
        cyc(C_AOE, 8'h00);
        chk("R5 A drive", {24'd0, bus_seen}, 32'h5C);
        cyc(C_BOE, 8'h00);
        chk("R5 B drive", {24'd0, bus_seen}, 32'hC3);
        cyc(C_BOE | C_LA, 8'h00);
        chk("R5 B to A transfer", {24'd0, a_o}, 32'hC3);

        // R9: address load and memory write in one cycle
        cyc(C_EXT | C_LAD, 8'h05);
        cyc(C_EXT | C_LAD | C_WE, 8'h39);
        exp_mem[5] = 8'h39;
        chk("R9 new address taken", {28'd0, addr_o}, 32'd9);
        chk_image("R9 write used old address");

        // R9: ALU feeding A twice in a row
        cyc(C_EXT | C_LA, 8'd10);
        cyc(C_EXT | C_LB, 8'd3);
        cyc(C_ALU | C_LA, 8'h00);
        chk("R9 accumulate first", {24'd0, a_o}, 32'd13);
        cyc(C_ALU | C_LA, 8'h00);
        chk("R9 accumulate second", {24'd0, a_o}, 32'd16);
        cyc(C_ALU | C_SUB | C_LA, 8'h00);
        chk("R9 accumulate subtract", {24'd0, a_o}, 32'd13);

        // R1: reset leaves memory untouched
        rst = 1'b1;
        cyc('0, 8'h00);
        rst = 1'b0;
        chk("R1 addr cleared", {28'd0, addr_o}, 32'd0);
        chk("R1 A cleared", {24'd0, a_o}, 32'd0);
        chk_image("R1 memory kept over reset");

        // R8: hand-sequenced 15 + 4 - 7 program
        mem_write(4'd0, 8'd15);
        mem_write(4'd1, 8'd4);
        mem_write(4'd2, 8'd7);
        cyc(C_EXT | C_LAD, 8'd0);
        cyc(C_MEM | C_LA, 8'h00);
        cyc(C_EXT | C_LAD, 8'd1);
        cyc(C_MEM | C_LB, 8'h00);
        cyc(C_EXT | C_LAD, 8'd3);
        cyc(C_ALU | C_WE, 8'h00);
        cyc(C_MEM | C_LA, 8'h00);
        cyc(C_EXT | C_LAD, 8'd2);
        cyc(C_MEM | C_LB, 8'h00);
        cyc(C_EXT | C_LAD, 8'd4);
        cyc(C_ALU | C_SUB | C_WE, 8'h00);
        exp_mem[3] = 8'd19;
        exp_mem[4] = 8'd12;
        chk("R8 sum stored", {24'd0, mem_image_o[3*8 +: 8]}, 32'd19);
        chk("R8 difference stored", {24'd0, mem_image_o[4*8 +: 8]}, 32'd12);
        chk_image("R8 program image");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule